// File: doc/BRIEF.md
# Two-Bit Frame-Modulation Pixel Scanner

This block drives a plain LED shift-register chain that has only on/off inputs. It still shows four brightness levels. Each pixel in the frame store holds a 2-bit level. The scanner walks the store one row at a time, serializes one on/off bit per pixel, strobes the row into the drivers, and moves on to the next row. A rolling frame phase counts 0, 1, 2 and then repeats. It advances once per complete pass over all rows. A pixel is lit in a given frame only when its level is greater than the current phase. Across each three-frame cycle, levels 0 to 3 are therefore lit for 0, 1, 2 and 3 frames.

The frame store is read through a synchronous port with one cycle of read latency. The scanner fetches the next byte while the current one is still being shifted, so the shift clock keeps the same spacing across byte boundaries. The default geometry is 128 columns by 48 rows. Four pixels are packed per byte, so each row uses 32 bytes.

Top module: `pxdim_scan`

## Requirements
- R1: Pixel column c of row r comes from store byte r*(COLS/4) + c/4. Columns 4k..4k+3 use bit fields [7:6], [5:4], [3:2] and [1:0] of that byte, and column 0 is shifted out first.
- R2: The serial bit for a pixel is 1 exactly when its 2-bit level is greater than the frame phase.
- R3: The frame phase is 0 after reset. It advances by one at the end of each complete frame and goes from 2 back to 0, so the phases of successive frames run 0, 1, 2, 0, 1.
- R4: Each pixel bit is held on the serial output for two cycles. The shift clock is low in the first cycle and high in the second, which gives exactly COLS shift clock pulses per row.
- R5: The row latch is high for exactly one cycle, directly after the high cycle of the last bit of the row. The shift clock is low in that cycle, and the row select shows the row being latched.
- R6: After each latch the row select advances by one, going from ROWS-1 back to 0.
- R7: Each row takes 2*COLS+3 cycles: a read of byte 0, a wait cycle, 2*COLS shift cycles, and one latch cycle. During shifting, the read of byte k+1 is issued in the first cycle of column 4k, for every byte except the last of the row.
- R8: The serial data output is 0 whenever no bit is being shifted.
- R9: A synchronous active-high reset clears the phase, the row and the column counters. While reset is held, latch, shift clock and serial data stay low and the row select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Frame store read enable |
| fb_addr | output | AW | Frame store byte address, row*(COLS/4)+byte |
| fb_rdata | input | 8 | Read data, valid one cycle after fb_rd_en |
| ser_data | output | 1 | Serial on/off pixel bit |
| shift_clk | output | 1 | Shift clock, one high cycle per bit |
| row_latch | output | 1 | One-cycle row latch strobe |
| row_sel | output | RW | Index of the row being scanned |

## Verification
The bench uses a 16-column, 3-row configuration and runs three store patterns, each for five frames, so that every phase value and the phase wrap both occur.

- A byte that repeats levels 0, 1, 2, 3 in each slot shows whether the slot order and the MSB-first packing are right, and whether the comparison is strict.
- Rows that are all level 3, all level 0 and all level 2 separate always-lit, never-lit and two-of-three behaviour.
- A scattered arithmetic pattern places a different byte at every address, so a wrong read address or a late prefetch swap shows up.

Every cycle is compared against a timeline computed from the cycle count.

// File: rtl/pxdim_pkg.sv
package pxdim_pkg;

  typedef enum logic [1:0] {
    SC_PRIME = 2'd0,
    SC_WAIT  = 2'd1,
    SC_SHIFT = 2'd2,
    SC_LATCH = 2'd3
  } scan_st_t;

  localparam logic [1:0] PHASE_LAST = 2'd2;

  // level of the pixel in slot 0..3 of a byte, slot 0 in the top bits
  function automatic logic [1:0] pix_level(input logic [7:0] b, input logic [1:0] slot);
    logic [1:0] lv;
    case (slot)
      2'd0: lv = b[7:6];
      2'd1: lv = b[5:4];
      2'd2: lv = b[3:2];
      default: lv = b[1:0];
    endcase
    return lv;
  endfunction

  function automatic logic pix_on(input logic [1:0] level, input logic [1:0] phase);
    return level > phase;
  endfunction

  function automatic logic [1:0] phase_next(input logic [1:0] p);
    return (p == PHASE_LAST) ? 2'd0 : p + 2'd1;
  endfunction

endpackage

// File: rtl/pxdim_phase.sv
module pxdim_phase (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output logic [1:0] phase
);
  import pxdim_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)      phase <= 2'd0;
    else if (adv) phase <= phase_next(phase);
  end
endmodule

// File: rtl/pxdim_seq.sv
module pxdim_seq #(
  parameter int COLS = 128,
  parameter int ROWS = 48,
  localparam int BPR = COLS / 4,
  localparam int CW  = $clog2(COLS),
  localparam int BW  = CW - 2,
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = $clog2(ROWS * BPR)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          load_first,
  output logic          swap,
  output logic [1:0]    slot,
  output logic          shifting,
  output logic          half,
  output logic          latch,
  output logic [RW-1:0] row,
  output logic          frame_end
);
  import pxdim_pkg::*;

  scan_st_t        st;
  logic [CW-1:0]   col;
  logic [BW-1:0]   byte_idx;
  logic [BW-1:0]   rd_byte;
  logic            last_col;
  logic            last_row;
  logic            last_byte;

  function automatic logic [AW-1:0] byte_addr(input logic [RW-1:0] r, input logic [BW-1:0] b);
    return AW'(r) * AW'(BPR) + AW'(b);
  endfunction

  assign byte_idx   = col[CW-1:2];
  assign slot       = col[1:0];
  assign last_col   = (col == CW'(COLS - 1));
  assign last_row   = (row == RW'(ROWS - 1));
  assign last_byte  = (byte_idx == BW'(BPR - 1));
  assign shifting   = (st == SC_SHIFT);
  assign latch      = (st == SC_LATCH);
  assign load_first = (st == SC_WAIT);
  assign frame_end  = latch && last_row;
  assign swap       = shifting && half && (slot == 2'd3);

  always_comb begin
    rd_req  = 1'b0;
    rd_byte = '0;
    if (st == SC_PRIME) begin
      rd_req = 1'b1;
    end else if (shifting && !half && slot == 2'd0 && !last_byte) begin
      rd_req  = 1'b1;
      rd_byte = byte_idx + BW'(1);
    end
  end

  assign rd_addr = byte_addr(row, rd_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SC_PRIME;
      row  <= '0;
      col  <= '0;
      half <= 1'b0;
    end else begin
      case (st)
        SC_PRIME: st <= SC_WAIT;
        SC_WAIT: begin
          st   <= SC_SHIFT;
          col  <= '0;
          half <= 1'b0;
        end
        SC_SHIFT: begin
          half <= ~half;
          if (half) begin
            if (last_col) begin
              st  <= SC_LATCH;
              col <= '0;
            end else begin
              col <= col + CW'(1);
            end
          end
        end
        default: begin
          st  <= SC_PRIME;
          row <= last_row ? '0 : row + RW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/pxdim_ser.sv
module pxdim_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       load_first,
  input  logic       swap,
  input  logic [1:0] slot,
  input  logic       shifting,
  input  logic [1:0] phase,
  input  logic [7:0] fb_rdata,
  output logic       ser_data
);
  import pxdim_pkg::*;

  logic       rd_pend;
  logic [7:0] cur_byte;
  logic [7:0] nxt_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      cur_byte <= '0;
      nxt_byte <= '0;
    end else begin
      rd_pend <= rd_req;
      if (rd_pend && load_first) cur_byte <= fb_rdata;
      else if (swap)             cur_byte <= nxt_byte;
      if (rd_pend && !load_first) nxt_byte <= fb_rdata;
    end
  end

  assign ser_data = shifting && pix_on(pix_level(cur_byte, slot), phase);
endmodule

// File: rtl/pxdim_scan.sv
module pxdim_scan #(
  parameter int COLS = 128,
  parameter int ROWS = 48,
  localparam int BPR = COLS / 4,
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = $clog2(ROWS * BPR)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          fb_rd_en,
  output logic [AW-1:0] fb_addr,
  input  logic [7:0]    fb_rdata,
  output logic          ser_data,
  output logic          shift_clk,
  output logic          row_latch,
  output logic [RW-1:0] row_sel
);
  logic       rd_req_w;
  logic       load_first_w;
  logic       swap_w;
  logic [1:0] slot_w;
  logic       shifting_w;
  logic       half_w;
  logic       latch_w;
  logic       frame_end_w;
  logic [1:0] phase_q;

  pxdim_seq #(.COLS(COLS), .ROWS(ROWS)) seq_i (
    .clk(clk), .rst(rst), .rd_req(rd_req_w), .rd_addr(fb_addr),
    .load_first(load_first_w), .swap(swap_w), .slot(slot_w),
    .shifting(shifting_w), .half(half_w), .latch(latch_w),
    .row(row_sel), .frame_end(frame_end_w)
  );

  pxdim_phase phase_i (
    .clk(clk), .rst(rst), .adv(frame_end_w), .phase(phase_q)
  );

  pxdim_ser ser_i (
    .clk(clk), .rst(rst), .rd_req(rd_req_w), .load_first(load_first_w),
    .swap(swap_w), .slot(slot_w), .shifting(shifting_w), .phase(phase_q),
    .fb_rdata(fb_rdata), .ser_data(ser_data)
  );

  assign fb_rd_en  = rd_req_w;
  assign shift_clk = shifting_w && half_w;
  assign row_latch = latch_w;
endmodule

// File: rtl/pxdim_chk.sv
module pxdim_chk #(
  parameter int ROWS = 48,
  parameter int RW   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          shift_clk,
  input logic          row_latch,
  input logic          ser_data,
  input logic [RW-1:0] row_sel,
  input logic [1:0]    phase,
  input logic          frame_end,
  input logic          shifting
);
  // R5
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    row_latch |=> !row_latch);
  // R5
  latch_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
    row_latch |-> !shift_clk);
  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (row_latch && row_sel != RW'(ROWS - 1)) |=> row_sel == $past(row_sel) + RW'(1));
  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (row_latch && row_sel == RW'(ROWS - 1)) |=> row_sel == '0);
  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !row_latch |=> $stable(row_sel));
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= 2'd2);
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(phase));
  // R4
  clk_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    shift_clk |=> !shift_clk);
  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_clk) |-> $stable(ser_data));
  // R8
  data_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shifting |-> !ser_data);
endmodule

bind pxdim_scan pxdim_chk #(.ROWS(ROWS), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .shift_clk(shift_clk), .row_latch(row_latch),
  .ser_data(ser_data), .row_sel(row_sel), .phase(phase_q),
  .frame_end(frame_end_w), .shifting(shifting_w)
);

// File: tb/pxdim_scan_tb.sv
module pxdim_scan_tb_top;
  localparam int COLS = 16;
  localparam int ROWS = 3;
  localparam int BPR  = COLS / 4;
  localparam int RW   = $clog2(ROWS);
  localparam int AW   = $clog2(ROWS * BPR);
  localparam int NB   = ROWS * BPR;
  localparam int P    = 2 * COLS + 3;
  localparam int NFR  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fb_rd_en;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_rdata = 8'h00;
  logic          ser_data;
  logic          shift_clk;
  logic          row_latch;
  logic [RW-1:0] row_sel;
  logic [7:0]    mem [NB];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pxdim_scan #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
    .fb_rdata(fb_rdata), .ser_data(ser_data), .shift_clk(shift_clk),
    .row_latch(row_latch), .row_sel(row_sel)
  );

  always @(posedge clk) if (fb_rd_en) fb_rdata <= mem[fb_addr];

  task automatic check(input string req, input int act, input int exp, input int t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  task automatic fill(input int pat);
    for (int a = 0; a < NB; a++) begin
      case (pat)
        0: mem[a] = 8'((a * 73 + 29) % 256);
        1: mem[a] = 8'h1B;
        default: mem[a] = (a / BPR == 0) ? 8'hFF : (a / BPR == 1) ? 8'h00 : 8'hAA;
      endcase
    end
  endtask

  task automatic run_pass(input int pat);
    fill(pat);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 latch", int'(row_latch), 0, -1);
    check("R9 sclk", int'(shift_clk), 0, -1);
    check("R9 data", int'(ser_data), 0, -1);
    check("R9 row", int'(row_sel), 0, -1);
    rst = 1'b0;
    for (int t = 0; t < NFR * ROWS * P; t++) begin
      int fr, r, o, ph, k, c, lvl, e_data, e_clk, e_rd, e_addr;
      fr = t / (P * ROWS);
      r  = (t / P) % ROWS;
      o  = t % P;
      ph = fr % 3;
      e_data = 0; e_clk = 0; e_rd = 0; e_addr = r * BPR;
      if (o == 0) e_rd = 1;
      if (o >= 2 && o < P - 1) begin
        k = o - 2;
        c = k / 2;
        e_clk = k % 2;
        lvl = (int'(mem[r * BPR + c / 4]) >> (6 - 2 * (c % 4))) % 4;
        e_data = (lvl > ph) ? 1 : 0;            // R1 R2 R3
        if (e_clk == 0 && c % 4 == 0 && c / 4 < BPR - 1) begin
          e_rd = 1;
          e_addr = r * BPR + c / 4 + 1;
        end
      end
      check("R1 R2 R3 R8 data", int'(ser_data), e_data, t);
      check("R4 sclk", int'(shift_clk), e_clk, t);
      check("R5 latch", int'(row_latch), (o == P - 1) ? 1 : 0, t);
      check("R6 row", int'(row_sel), r, t);
      check("R7 rd_en", int'(fb_rd_en), e_rd, t);
      if (e_rd == 1) check("R7 addr", int'(fb_addr), e_addr, t);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int p = 0; p < 3; p++) run_pass(p);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule